// File: doc/BRIEF.md
# Banked Asynchronous ROM Read Sequencer

This block sits on the clock of the host logic and fetches single bytes from a row of up to four asynchronous 64K x 8 UV-erasable ROMs that share one address bus and one data bus. A request carries an 18-bit address. The top two bits pick the device and the low sixteen bits are the location inside it. The sequencer places the location on the shared address bus first. It then lowers the chip enable of the selected device and, later, the common output enable. It waits out the access time in clock cycles, captures the byte and returns it with a one-cycle valid strobe.

Every analog delay of the memory is a parameter in nanoseconds, together with the clock period. Each delay is converted to a whole number of cycles by rounding up. The per-device chip enable is the select: devices that are not addressed stay in standby with their chip enable high. Output enable is one read strobe shared by all devices. Any data is seen only while the selected chip enable and the output enable are both low. A device's outputs take a while to float after its strobes rise. For that reason, a read aimed at a different device waits until a float counter started by the previous access has run out.

Cycle counts used below: ACC = ceil(max(T_ACC_NS, T_CE_NS) / CLK_NS), OEC = ceil(T_OE_NS / CLK_NS), ACT = max(ACC, OEC), LEAD = ACT - OEC, DFC = ceil(T_DF_NS / CLK_NS). With the defaults (20 ns clock, 90/90/45/35 ns) these are ACT = 5, OEC = 3, LEAD = 2 and DFC = 2.

Top module: `eprom_rd_ctrl`

## Requirements
- R1: While reset is asserted (synchronous, active high) and in the first cycle after it, ready is 1, rvalid is 0, all chip enables are 1 and output enable is 1.
- R2: The location addr[15:0] of an accepted request is on mem_addr in the cycle before any chip enable falls. It stays unchanged for every cycle in which a chip enable is low.
- R3: At most one chip enable is low at any time. The one that goes low is bit addr[17:16] of mem_ce_n, where bit 0 is device 0.
- R4: The chip enable stays low for exactly ACT consecutive cycles. The byte is captured at the clock edge that ends that window.
- R5: Output enable is low only while a chip enable is low. It falls LEAD cycles after the chip enable falls and stays low for exactly OEC cycles.
- R6: rvalid is a single-cycle pulse. It rises ACT cycles after the chip enable fell, and rdata then holds the byte that was present on mem_dq at the capture edge.
- R7: In the cycle where rvalid is 1, all chip enables and the output enable are already back at 1 and ready is 1 again.
- R8: Take the case where a request is accepted in the first cycle after rvalid. If it targets a different device, its chip enable falls max(2, DFC+1) cycles after the previous chip enable rose. If it targets the same device, it falls 2 cycles after. A request made after the float counter has expired is never delayed.
- R9: A request raised while ready is 0 is ignored. It does not change mem_addr, it does not start a second access and it produces no extra rvalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Read request, taken in a cycle where ready is 1 |
| addr | input | 18 | Device number in bits 17:16, location in bits 15:0 |
| ready | output | 1 | High when a new request can be taken |
| rdata | output | 8 | Byte read by the last access |
| rvalid | output | 1 | One-cycle strobe marking rdata as new |
| mem_addr | output | 16 | Shared address bus to the devices |
| mem_ce_n | output | 4 | Chip enable per device, active low |
| mem_oe_n | output | 1 | Common output enable, active low |
| mem_dq | input | 8 | Shared data bus from the devices |

## Verification
A wrong step count or a mis-decoded device shows at the pins in the same access. The strobe pattern stretches, shifts or lights two chip enables. If the capture edge is early, the bench's memory model has not yet put valid data on the bus, so rdata carries a byte with bit 7 set that no location ever holds. A float counter that is stale or skipped shows only on the next read, as a chip enable that falls one cycle too soon or too late after a change of device. Because of this, the sweep alternates devices back-to-back as well as repeating them.

// File: rtl/eprom_rd_pkg.sv
`timescale 1ns/1ps
package eprom_rd_pkg;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_ADDR = 2'd1,
    S_ACT  = 2'd2
  } rd_state_t;

  // nanoseconds to whole clock cycles, rounded up
  function automatic int ns2cyc(input int ns, input int period);
    return (ns + period - 1) / period;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/eprom_ce_decode.sv
`timescale 1ns/1ps
module eprom_ce_decode #(
  parameter int BANK_W = 2,
  localparam int N_BANK = 2 ** BANK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [BANK_W-1:0] sel,
  output logic [N_BANK-1:0] ce_n
);

  // one registered active-low select per device
  for (genvar g = 0; g < N_BANK; g++) begin : g_ce
    always_ff @(posedge clk) begin
      if (rst) ce_n[g] <= 1'b1;
      else     ce_n[g] <= !(en && (sel == BANK_W'(g)));
    end
  end

endmodule

// File: rtl/eprom_float_guard.sv
`timescale 1ns/1ps
module eprom_float_guard #(
  parameter int BANK_W = 2,
  parameter int DF_CYC = 2,
  localparam int DF_W = $clog2(DF_CYC + 1) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rel,
  input  logic [BANK_W-1:0] bank,
  output logic              clear_ok
);

  logic [DF_W-1:0]   df_q;
  logic [BANK_W-1:0] last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      df_q   <= '0;
      last_q <= '0;
    end else if (rel) begin
      df_q   <= DF_W'(DF_CYC);
      last_q <= bank;
    end else if (df_q != '0) begin
      df_q <= df_q - 1'b1;
    end
  end

  // the device that just released may drive again at once
  assign clear_ok = (df_q == '0) || (bank == last_q);

endmodule

// File: rtl/eprom_rd_ctrl.sv
`timescale 1ns/1ps
module eprom_rd_ctrl
  import eprom_rd_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int BANK_W   = 2,
  parameter int DATA_W   = 8,
  parameter int CLK_NS   = 20,
  parameter int T_ACC_NS = 90,
  parameter int T_CE_NS  = 90,
  parameter int T_OE_NS  = 45,
  parameter int T_DF_NS  = 35,
  localparam int N_BANK  = 2 ** BANK_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req,
  input  logic [BANK_W+ADDR_W-1:0] addr,
  output logic                     ready,
  output logic [DATA_W-1:0]        rdata,
  output logic                     rvalid,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic [N_BANK-1:0]        mem_ce_n,
  output logic                     mem_oe_n,
  input  logic [DATA_W-1:0]        mem_dq
);

  localparam int ACC_CYC  = imax(ns2cyc(T_ACC_NS, CLK_NS), ns2cyc(T_CE_NS, CLK_NS));
  localparam int OE_CYC   = ns2cyc(T_OE_NS, CLK_NS);
  localparam int ACT_CYC  = imax(ACC_CYC, OE_CYC);
  localparam int LEAD_CYC = ACT_CYC - OE_CYC;
  localparam int DF_CYC   = ns2cyc(T_DF_NS, CLK_NS);
  localparam int CNT_W    = $clog2(ACT_CYC + 1) + 1;
  localparam bit OE_WITH_CE = (LEAD_CYC == 0);

  rd_state_t         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BANK_W-1:0] bank_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;
  logic              ready_q;
  logic              oe_n_q;
  logic              clear_ok;
  logic              go;
  logic              done;
  logic              ce_en_d;

  always_comb begin
    go      = (state_q == S_ADDR) && clear_ok;
    done    = (state_q == S_ACT) && (cnt_q == CNT_W'(ACT_CYC));
    ce_en_d = go || ((state_q == S_ACT) && !done);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= S_IDLE;
      cnt_q    <= '0;
      bank_q   <= '0;
      addr_q   <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      ready_q  <= 1'b1;
      oe_n_q   <= 1'b1;
    end else begin
      rvalid_q <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (req) begin
            addr_q  <= addr[ADDR_W-1:0];
            bank_q  <= addr[BANK_W+ADDR_W-1:ADDR_W];
            ready_q <= 1'b0;
            state_q <= S_ADDR;
          end
        end
        S_ADDR: begin
          if (go) begin
            cnt_q   <= CNT_W'(1);
            state_q <= S_ACT;
            if (OE_WITH_CE) oe_n_q <= 1'b0;
          end
        end
        S_ACT: begin
          if (done) begin
            rdata_q  <= mem_dq;
            rvalid_q <= 1'b1;
            ready_q  <= 1'b1;
            oe_n_q   <= 1'b1;
            state_q  <= S_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(LEAD_CYC)) oe_n_q <= 1'b0;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  eprom_ce_decode #(
    .BANK_W(BANK_W)
  ) u_dec (
    .clk (clk),
    .rst (rst),
    .en  (ce_en_d),
    .sel (bank_q),
    .ce_n(mem_ce_n)
  );

  eprom_float_guard #(
    .BANK_W(BANK_W),
    .DF_CYC(DF_CYC)
  ) u_guard (
    .clk     (clk),
    .rst     (rst),
    .rel     (done),
    .bank    (bank_q),
    .clear_ok(clear_ok)
  );

  assign ready    = ready_q;
  assign rdata    = rdata_q;
  assign rvalid   = rvalid_q;
  assign mem_addr = addr_q;
  assign mem_oe_n = oe_n_q;

endmodule

// File: rtl/eprom_rd_ctrl_chk.sv
`timescale 1ns/1ps
module eprom_rd_ctrl_chk
  import eprom_rd_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int BANK_W   = 2,
  parameter int CLK_NS   = 20,
  parameter int T_ACC_NS = 90,
  parameter int T_CE_NS  = 90,
  parameter int T_OE_NS  = 45,
  parameter int T_DF_NS  = 35,
  localparam int N_BANK  = 2 ** BANK_W
) (
  input logic              clk,
  input logic              rst,
  input logic              ready,
  input logic              rvalid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [N_BANK-1:0] mem_ce_n,
  input logic              mem_oe_n
);

  localparam int ACT_CYC = imax(imax(ns2cyc(T_ACC_NS, CLK_NS), ns2cyc(T_CE_NS, CLK_NS)),
                                ns2cyc(T_OE_NS, CLK_NS));
  localparam int DF_CYC  = ns2cyc(T_DF_NS, CLK_NS);
  localparam int HC_W    = $clog2(DF_CYC + 2) + 1;
  localparam int LL_W    = $clog2(ACT_CYC + 2) + 1;

  logic              ce_any;
  logic              ce_prev;
  logic [BANK_W-1:0] cur_bank;
  logic [BANK_W-1:0] last_bank;
  logic              seen;
  logic [HC_W-1:0]   high_cnt;
  logic [LL_W-1:0]   low_len;

  assign ce_any = (mem_ce_n != '1);

  always_comb begin
    cur_bank = '0;
    for (int i = 0; i < N_BANK; i++) begin
      if (!mem_ce_n[i]) cur_bank = BANK_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_prev   <= 1'b0;
      last_bank <= '0;
      seen      <= 1'b0;
      high_cnt  <= '0;
      low_len   <= '0;
    end else begin
      ce_prev <= ce_any;
      if (ce_any) begin
        high_cnt  <= '0;
        low_len   <= ce_prev ? low_len + 1'b1 : LL_W'(1);
        last_bank <= cur_bank;
        seen      <= 1'b1;
      end else if (high_cnt != '1) begin
        high_cnt <= high_cnt + 1'b1;
      end
    end
  end

  p_addr_hold_r2: assert property (@(posedge clk) disable iff (rst)
    ce_any |-> $stable(mem_addr));

  p_one_select_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~mem_ce_n));

  p_select_window_r4: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> (low_len == LL_W'(ACT_CYC)));

  p_oe_inside_ce_r5: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> ce_any);

  p_single_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    rvalid |=> !rvalid);

  p_released_r7: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> (!ce_any && mem_oe_n && ready));

  p_float_gap_r8: assert property (@(posedge clk) disable iff (rst)
    (ce_any && !ce_prev && seen && (cur_bank != last_bank)) |-> (high_cnt >= HC_W'(DF_CYC)));

  p_busy_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !ready |=> $stable(mem_addr));

endmodule

bind eprom_rd_ctrl eprom_rd_ctrl_chk #(
  .ADDR_W  (ADDR_W),
  .BANK_W  (BANK_W),
  .CLK_NS  (CLK_NS),
  .T_ACC_NS(T_ACC_NS),
  .T_CE_NS (T_CE_NS),
  .T_OE_NS (T_OE_NS),
  .T_DF_NS (T_DF_NS)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .ready   (ready),
  .rvalid  (rvalid),
  .mem_addr(mem_addr),
  .mem_ce_n(mem_ce_n),
  .mem_oe_n(mem_oe_n)
);

// File: tb/test_eprom_rd_ctrl.sv
`timescale 1ns/1ps
module test_eprom_rd_ctrl;

  localparam int T_CLK = 20;
  localparam int T_ACC = 90;
  localparam int T_CE  = 90;
  localparam int T_OE  = 45;
  localparam int T_DF  = 35;
  localparam int C_ACC = (((T_ACC > T_CE) ? T_ACC : T_CE) + T_CLK - 1) / T_CLK;
  localparam int C_OE  = (T_OE + T_CLK - 1) / T_CLK;
  localparam int C_ACT = (C_ACC > C_OE) ? C_ACC : C_OE;
  localparam int C_LD  = C_ACT - C_OE;
  localparam int C_DF  = (T_DF + T_CLK - 1) / T_CLK;
  localparam int GAP_X = (C_DF + 1 > 2) ? C_DF + 1 : 2;

  logic        clk;
  logic        rst;
  logic        req;
  logic [17:0] addr;
  logic        ready;
  logic [7:0]  rdata;
  logic        rvalid;
  logic [15:0] mem_addr;
  logic [3:0]  mem_ce_n;
  logic        mem_oe_n;
  logic [7:0]  mem_dq;

  int total = 0;
  int fails = 0;
  bit finished = 0;
  logic [1:0] prev_bank = 2'd0;

  eprom_rd_ctrl i_eprom_rd_ctrl (
    .clk(clk), .rst(rst), .req(req), .addr(addr), .ready(ready),
    .rdata(rdata), .rvalid(rvalid), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_dq(mem_dq)
  );

  initial clk = 1'b0;
  always #(T_CLK/2) clk = ~clk;

  // contents of each device: bit 7 always 0, so the 8'hEE "not ready" byte never matches
  function automatic logic [7:0] romval(input logic [1:0] b, input logic [15:0] a);
    return {1'b0, a[6:0] ^ a[13:7] ^ {a[15:14], b, 3'b101}};
  endfunction

  // behavioural memory row: a byte appears only after every delay has elapsed
  int ce_run = 0, oe_run = 0, addr_run = 0;
  logic [15:0] addr_prev = '0;
  logic [1:0]  run_bank = '0;
  always @(negedge clk) begin
    if (rst) begin
      ce_run = 0; oe_run = 0; addr_run = 0; addr_prev = mem_addr; mem_dq = 8'hEE;
    end else begin
      if (mem_addr !== addr_prev) addr_run = 1;
      else if (addr_run < 1000) addr_run++;
      addr_prev = mem_addr;
      if ($countones(~mem_ce_n) == 1) begin
        logic [1:0] idx;
        idx = 2'd0;
        for (int i = 0; i < 4; i++) if (!mem_ce_n[i]) idx = 2'(i);
        if (ce_run > 0 && idx == run_bank) ce_run++;
        else ce_run = 1;
        run_bank = idx;
      end else ce_run = 0;
      if (!mem_oe_n) oe_run++;
      else oe_run = 0;
      mem_dq = (ce_run * T_CLK >= T_CE && oe_run * T_CLK >= T_OE && addr_run * T_CLK >= T_ACC)
               ? romval(run_bank, mem_addr) : 8'hEE;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // call at a negedge; returns at the negedge where rvalid is seen
  task automatic do_read(input logic [17:0] a, input bit b2b);
    int cyc, ce_first, oe_first, ce_cnt, oe_cnt, exp_gap;
    bit done, addr_ok, sel_ok, oe_ok;
    logic [3:0] exp_ce;
    exp_ce  = ~(4'b0001 << a[17:16]);
    exp_gap = (b2b && a[17:16] != prev_bank) ? GAP_X : 2;
    req = 1'b1; addr = a;
    cyc = 0; ce_first = -1; oe_first = -1; ce_cnt = 0; oe_cnt = 0;
    done = 0; addr_ok = 1; sel_ok = 1; oe_ok = 1;
    while (!done) begin
      @(negedge clk);
      cyc++;
      req = 1'b0;
      if (mem_addr !== a[15:0]) addr_ok = 0;
      if (mem_ce_n !== 4'hF) begin
        if (mem_ce_n !== exp_ce) sel_ok = 0;
        if (ce_first < 0) ce_first = cyc;
        ce_cnt++;
      end
      if (mem_oe_n === 1'b0) begin
        if (mem_ce_n === 4'hF) oe_ok = 0;
        if (oe_first < 0) oe_first = cyc;
        oe_cnt++;
      end
      if (rvalid === 1'b1 || cyc > 60) done = 1;
    end
    chk(addr_ok, "R2", "address held from setup to release", addr_ok, 1);
    chk(sel_ok, "R3", "decoded chip enable", mem_ce_n, exp_ce);
    chk(ce_cnt == C_ACT, "R4", "chip enable low cycles", ce_cnt, C_ACT);
    chk(oe_ok, "R5", "output enable only with chip enable", oe_ok, 1);
    chk(oe_first - ce_first == C_LD, "R5", "output enable lag", oe_first - ce_first, C_LD);
    chk(oe_cnt == C_OE, "R5", "output enable low cycles", oe_cnt, C_OE);
    chk(cyc - ce_first == C_ACT, "R6", "rvalid after chip enable", cyc - ce_first, C_ACT);
    chk(rdata === romval(a[17:16], a[15:0]), "R6", "read byte", rdata, romval(a[17:16], a[15:0]));
    chk(mem_ce_n === 4'hF && mem_oe_n === 1'b1 && ready === 1'b1, "R7", "strobes released with rvalid",
        {ready, mem_oe_n, mem_ce_n}, 6'h3F);
    chk(ce_first == exp_gap, "R8", "cycles to chip enable fall", ce_first, exp_gap);
    prev_bank = a[17:16];
  endtask

  // R9: request held high with other addresses throughout the access
  task automatic busy_read(input logic [17:0] a);
    int cyc, extra;
    bit done, addr_ok;
    req = 1'b1; addr = a; cyc = 0; done = 0; addr_ok = 1; extra = 0;
    while (!done) begin
      @(negedge clk);
      cyc++;
      if (mem_addr !== a[15:0]) addr_ok = 0;
      if (rvalid === 1'b1 || cyc > 60) done = 1;
      else begin
        req = 1'b1; addr = {~a[17:16], ~a[15:0]};
      end
    end
    req = 1'b0;
    chk(addr_ok, "R9", "address unchanged by busy requests", addr_ok, 1);
    chk(rdata === romval(a[17:16], a[15:0]), "R9", "byte of first request", rdata, romval(a[17:16], a[15:0]));
    chk(cyc == C_ACT + 2, "R9", "single access latency", cyc, C_ACT + 2);
    repeat (6) begin
      @(negedge clk);
      if (rvalid === 1'b1 || mem_ce_n !== 4'hF) extra++;
    end
    chk(extra == 0, "R9", "no access started by busy requests", extra, 0);
    prev_bank = a[17:16];
  endtask

  initial begin
    req = 1'b0; addr = '0; rst = 1'b1;
    repeat (3) @(posedge clk);
    // R1: values while reset is still applied
    @(negedge clk);
    chk(ready === 1'b1 && rvalid === 1'b0, "R1", "ready/rvalid in reset", {ready, rvalid}, 2'b10);
    rst = 1'b0;
    @(negedge clk);
    chk(ready === 1'b1, "R1", "ready after reset", ready, 1);
    chk(rvalid === 1'b0, "R1", "rvalid after reset", rvalid, 0);
    chk(mem_ce_n === 4'hF, "R1", "chip enables after reset", mem_ce_n, 4'hF);
    chk(mem_oe_n === 1'b1, "R1", "output enable after reset", mem_oe_n, 1);

    // sweep: first half changes device every read, second half mostly repeats it
    for (int r = 0; r < 64; r++) begin
      logic [1:0]  b;
      logic [15:0] lo;
      b  = (r < 32) ? 2'(r) : 2'(r >> 3);
      lo = 16'(r * 16'h0B31) ^ 16'(r << 9);
      if (r == 63) lo = 16'hFFFF;
      if (r == 0)  lo = 16'h0000;
      do_read({b, lo}, r != 0);
    end

    // R8: after the float counter has expired a new device starts at once
    repeat (C_DF + 3) @(negedge clk);
    do_read({2'd2, 16'h5AA5}, 1'b0);

    repeat (3) @(negedge clk);
    busy_read({2'd1, 16'hC3A0});

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule